// File: doc/BRIEF.md
# Bounded Saturating Add/Subtract Unit

This unit adds an unsigned step to an unsigned operand, or takes the step away from it, and clamps the outcome to a window set by a lower and an upper bound. The bounds can be any values; they need not be symmetric or powers of two. Clamping can be switched off. When it is off, the result wraps around modulo the lane width.

The 32-bit datapath has two modes. In the wide mode it runs as one 32-bit lane. In the packed mode it runs as two independent 16-bit lanes, and each lane takes its operand, step and bounds from its own half of the input words. Every accepted operation produces a registered result one cycle later. It also produces a per-lane flag that says whether that operation clamped. A sticky per-lane status collects these clamp events over a run of operations until it is cleared explicitly.

Top module: `satclamp_unit`

## Requirements
- R1: With clamping enabled, an addition returns the smaller of operand+step and the upper bound. A sum that carries out of the lane width counts as above the upper bound.
- R2: With clamping enabled, a subtraction returns the larger of operand−step and the lower bound. A difference that borrows below zero counts as below the lower bound.
- R3: With clamping enabled, the result is min(max(v, lower), upper) for the exact value v. An addition that lands below the lower bound gives the lower bound, and a subtraction that lands above the upper bound gives the upper bound.
- R4: When the lower bound is greater than the upper bound and clamping is enabled, the result equals the upper bound and the lane flag is set.
- R5: With `sat_en` low, the result is the sum or difference modulo 2^lane width, and `sat_now` is 0.
- R6: With `dual_mode` high, lane i uses bits [16i+15:16i] of operand, step, bounds and result. A carry or borrow in lane 0 never reaches lane 1.
- R7: With `dual_mode` low, one 32-bit operation uses the full words. Its clamp flag appears on bit 0, and bit 1 stays 0.
- R8: `sat_now[i]` is 1 exactly when lane i of the last accepted operation had its exact value outside [lower, upper].
- R9: `sat_sticky[i]` is set by any accepted operation that clamps lane i. It is cleared only by `clr_flags`. A clamp event in the same cycle as a clear leaves that bit set.
- R10: `out_valid` is `in_valid` delayed by one cycle. `result` and `sat_now` change only on a cycle with `in_valid` high.
- R11: After reset, `out_valid`, `result`, `sat_now` and `sat_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| op_sub | input | 1 | 1 = subtract step, 0 = add step |
| sat_en | input | 1 | 1 = clamp to bounds, 0 = wrap |
| dual_mode | input | 1 | 1 = two 16-bit lanes, 0 = one 32-bit lane |
| operand | input | 32 | Value operated on |
| step | input | 32 | Unsigned step |
| bound_lo | input | 32 | Lower bound(s) |
| bound_hi | input | 32 | Upper bound(s) |
| clr_flags | input | 1 | Clear sticky status |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| sat_now | output | 2 | Per-lane clamp flags of the last operation |
| sat_sticky | output | 2 | Accumulated per-lane clamp status |

## Verification
The tests first use in-range values, which must pass through unchanged. Then they use values just past each bound and values that carry out of the lane or borrow below zero. Together these separate a clamp decided on the wide intermediate from one decided on the truncated word. The same operations are repeated in wrap mode and in packed mode. This shows that clamping can really be switched off and that one lane's overflow does not leak into its neighbour. Finally, clear and set events are interleaved, once in separate cycles and once in the same cycle, to pin down which one wins for the sticky status.

// File: rtl/satclamp_pkg.sv
package satclamp_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/satclamp_lane.sv
module satclamp_lane
    import satclamp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic         sub_i,
    input  logic         sat_en_i,
    output logic [W-1:0] y_o,
    output logic         clamp_o
);
    op_e        op;
    logic [W:0] ext;     // one guard bit: carry on add, borrow on subtract
    logic       neg;
    logic       below;
    logic       above;

    assign op = op_e'(sub_i);

    always_comb begin
        if (op == OP_SUB) begin
            ext = {1'b0, a_i} - {1'b0, s_i};
        end else begin
            ext = {1'b0, a_i} + {1'b0, s_i};
        end
        neg   = (op == OP_SUB) && ext[W];
        below = neg || (ext < {1'b0, lo_i});
        above = !neg && (ext > {1'b0, hi_i});

        y_o     = ext[W-1:0];
        clamp_o = 1'b0;
        if (sat_en_i) begin
            clamp_o = below || above;
            if (below) begin
                // raising to lo then capping at hi: an inverted window yields hi
                y_o = (lo_i > hi_i) ? hi_i : lo_i;
            end else if (above) begin
                y_o = hi_i;
            end
        end
    end
endmodule

// File: rtl/satclamp_unit.sv
module satclamp_unit #(
    parameter int DATA_W    = 32,
    parameter int NUM_LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 op_sub,
    input  logic                 sat_en,
    input  logic                 dual_mode,
    input  logic [DATA_W-1:0]    operand,
    input  logic [DATA_W-1:0]    step,
    input  logic [DATA_W-1:0]    bound_lo,
    input  logic [DATA_W-1:0]    bound_hi,
    input  logic                 clr_flags,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic [NUM_LANES-1:0] sat_now,
    output logic [NUM_LANES-1:0] sat_sticky
);
    localparam int LANE_W = DATA_W / NUM_LANES;

    typedef struct packed {
        logic                 vld;
        logic [DATA_W-1:0]    res;
        logic [NUM_LANES-1:0] now;
        logic [NUM_LANES-1:0] sticky;
    } state_t;

    state_t state_d, state_q;

    logic [DATA_W-1:0]    packed_y;
    logic [NUM_LANES-1:0] packed_clamp;
    logic [DATA_W-1:0]    wide_y;
    logic                 wide_clamp;
    logic [NUM_LANES-1:0] wide_flags;
    logic [NUM_LANES-1:0] new_flags;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        satclamp_lane #(.W(LANE_W)) u_lane (
            .a_i      (operand [i*LANE_W +: LANE_W]),
            .s_i      (step    [i*LANE_W +: LANE_W]),
            .lo_i     (bound_lo[i*LANE_W +: LANE_W]),
            .hi_i     (bound_hi[i*LANE_W +: LANE_W]),
            .sub_i    (op_sub),
            .sat_en_i (sat_en),
            .y_o      (packed_y[i*LANE_W +: LANE_W]),
            .clamp_o  (packed_clamp[i])
        );
    end

    satclamp_lane #(.W(DATA_W)) u_wide (
        .a_i      (operand),
        .s_i      (step),
        .lo_i     (bound_lo),
        .hi_i     (bound_hi),
        .sub_i    (op_sub),
        .sat_en_i (sat_en),
        .y_o      (wide_y),
        .clamp_o  (wide_clamp)
    );

    always_comb begin
        wide_flags    = '0;
        wide_flags[0] = wide_clamp;
        new_flags     = dual_mode ? packed_clamp : wide_flags;

        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = dual_mode ? packed_y : wide_y;
            state_d.now = new_flags;
        end
        // a clamp event in the clear cycle survives the clear
        state_d.sticky = (clr_flags ? '0 : state_q.sticky)
                       | (in_valid ? new_flags : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.vld;
    assign result     = state_q.res;
    assign sat_now    = state_q.now;
    assign sat_sticky = state_q.sticky;
endmodule

// File: rtl/satclamp_unit_chk.sv
module satclamp_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 sat_en,
    input logic                 dual_mode,
    input logic [DATA_W-1:0]    bound_lo,
    input logic [DATA_W-1:0]    bound_hi,
    input logic                 clr_flags,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    result,
    input logic [NUM_LANES-1:0] sat_now,
    input logic [NUM_LANES-1:0] sat_sticky
);
    localparam int LANE_W = DATA_W / NUM_LANES;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(sat_now)));

    // R9
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_flags |=> ((sat_sticky & $past(sat_sticky)) == $past(sat_sticky)));

    // R9
    sticky_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((sat_now & ~sat_sticky) == '0));

    // R5
    wrap_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_en) |=> (sat_now == '0));

    // R7
    wide_upper_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dual_mode) |=> !sat_now[NUM_LANES-1]);

    // R3
    wide_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !dual_mode && (bound_lo <= bound_hi))
        |=> ((result >= $past(bound_lo)) && (result <= $past(bound_hi))));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_chk
        // R6
        lane_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sat_en && dual_mode
             && (bound_lo[i*LANE_W +: LANE_W] <= bound_hi[i*LANE_W +: LANE_W]))
            |=> ((result[i*LANE_W +: LANE_W] >= $past(bound_lo[i*LANE_W +: LANE_W]))
              && (result[i*LANE_W +: LANE_W] <= $past(bound_hi[i*LANE_W +: LANE_W]))));
    end
endmodule

bind satclamp_unit satclamp_unit_chk #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .sat_en     (sat_en),
    .dual_mode  (dual_mode),
    .bound_lo   (bound_lo),
    .bound_hi   (bound_hi),
    .clr_flags  (clr_flags),
    .out_valid  (out_valid),
    .result     (result),
    .sat_now    (sat_now),
    .sat_sticky (sat_sticky)
);

// File: tb/satclamp_unit_tb_top.sv
`timescale 1ns/1ps
module satclamp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic        sat_en = 1'b0;
    logic        dual_mode = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] step = '0;
    logic [31:0] bound_lo = '0;
    logic [31:0] bound_hi = '0;
    logic        clr_flags = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [1:0]  sat_now;
    logic [1:0]  sat_sticky;

    int n_checks = 0;
    int n_errors = 0;

    logic        got_vld;
    logic [31:0] got_res;
    logic [1:0]  got_now;
    logic [1:0]  got_sticky;
    logic [1:0]  exp_sticky = '0;

    always #2 clk = ~clk;   // 250 MHz

    satclamp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .sat_en(sat_en), .dual_mode(dual_mode), .operand(operand), .step(step),
        .bound_lo(bound_lo), .bound_hi(bound_hi), .clr_flags(clr_flags),
        .out_valid(out_valid), .result(result), .sat_now(sat_now),
        .sat_sticky(sat_sticky)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference: min(max(v, lo), hi) on the exact value, or modulo wrap
    task automatic model_lane(input bit sub, input bit sat, input int w,
                              input longint a, input longint s,
                              input longint lo, input longint hi,
                              output longint y, output bit f);
        longint v;
        longint mask;
        v    = sub ? (a - s) : (a + s);
        mask = (longint'(1) << w) - 1;
        if (!sat) begin
            y = v & mask;
            f = 1'b0;
        end else begin
            y = v;
            if (y < lo) y = lo;
            if (y > hi) y = hi;
            f = (v < lo) || (v > hi);
        end
    endtask

    task automatic drive(bit sub, bit sat, bit dual, logic [31:0] a, logic [31:0] s,
                         logic [31:0] lo, logic [31:0] hi, bit clr, bit vld);
        @(negedge clk);
        op_sub = sub; sat_en = sat; dual_mode = dual;
        operand = a; step = s; bound_lo = lo; bound_hi = hi;
        clr_flags = clr; in_valid = vld;
        @(posedge clk);
        #1;
        got_vld = out_valid; got_res = result; got_now = sat_now; got_sticky = sat_sticky;
        @(negedge clk);
        in_valid = 1'b0; clr_flags = 1'b0;
    endtask

    task automatic run(string req, bit sub, bit sat, bit dual, logic [31:0] a,
                       logic [31:0] s, logic [31:0] lo, logic [31:0] hi, bit clr);
        logic [31:0] exp_res;
        logic [1:0]  exp_now;
        longint      y;
        bit          f;
        exp_res = '0;
        exp_now = '0;
        if (dual) begin
            for (int i = 0; i < 2; i++) begin
                model_lane(sub, sat, 16, longint'(a[16*i +: 16]), longint'(s[16*i +: 16]),
                           longint'(lo[16*i +: 16]), longint'(hi[16*i +: 16]), y, f);
                exp_res[16*i +: 16] = y[15:0];
                exp_now[i] = f;
            end
        end else begin
            model_lane(sub, sat, 32, longint'(a), longint'(s), longint'(lo), longint'(hi), y, f);
            exp_res = y[31:0];
            exp_now = {1'b0, f};
        end
        exp_sticky = (clr ? 2'b00 : exp_sticky) | exp_now;
        drive(sub, sat, dual, a, s, lo, hi, clr, 1'b1);
        check(req, got_res, exp_res);
        check({req, " R8 flags"}, {30'd0, got_now}, {30'd0, exp_now});
        check("R9 sticky", {30'd0, got_sticky}, {30'd0, exp_sticky});
        check("R10 valid", {31'd0, got_vld}, 32'd1);
    endtask

    task automatic t_reset();
        #1;
        check("R11 valid", {31'd0, out_valid}, 32'd0);
        check("R11 result", result, 32'd0);
        check("R11 now", {30'd0, sat_now}, 32'd0);
        check("R11 sticky", {30'd0, sat_sticky}, 32'd0);
    endtask

    task automatic t_add_wide();
        run("R1 add in range", 0, 1, 0, 32'd5, 32'd3, 32'd0, 32'd100, 0);
        run("R1 add above hi", 0, 1, 0, 32'd100, 32'd50, 32'd10, 32'd120, 0);
        run("R1 add carry out", 0, 1, 0, 32'hFFFF_FFF0, 32'h20, 32'd0, 32'hFFFF_FFFF, 0);
        run("R1 add exact hi", 0, 1, 0, 32'd70, 32'd50, 32'd10, 32'd120, 0);
    endtask

    task automatic t_sub_wide();
        run("R2 sub borrow", 1, 1, 0, 32'd10, 32'd20, 32'd3, 32'd100, 0);
        run("R2 sub below lo", 1, 1, 0, 32'd50, 32'd10, 32'd45, 32'd100, 0);
        run("R2 sub in range", 1, 1, 0, 32'd50, 32'd5, 32'd45, 32'd100, 0);
    endtask

    task automatic t_general();
        run("R3 add below lo", 0, 1, 0, 32'd2, 32'd3, 32'd10, 32'd20, 0);
        run("R3 sub above hi", 1, 1, 0, 32'd200, 32'd10, 32'd0, 32'd100, 0);
    endtask

    task automatic t_inverted();
        run("R4 inverted add", 0, 1, 0, 32'd30, 32'd0, 32'd50, 32'd20, 0);
        run("R4 inverted sub", 1, 1, 0, 32'd10, 32'd5, 32'd50, 32'd20, 0);
    endtask

    task automatic t_wrap();
        run("R5 wrap add", 0, 0, 0, 32'hFFFF_FFFF, 32'd1, 32'd5, 32'd9, 0);
        run("R5 wrap sub", 1, 0, 0, 32'd0, 32'd1, 32'd5, 32'd9, 0);
        run("R5 wrap dual", 0, 0, 1, 32'h0003_FFFF, 32'h0001_0001, 32'd0, 32'd0, 0);
    endtask

    task automatic t_dual();
        run("R6 lane0 clamp", 0, 1, 1, 32'h0010_FFF0, 32'h0002_0020, 32'h0000_0000, 32'h0100_FFFF, 0);
        run("R6 lane1 clamp", 1, 1, 1, 32'h0005_0080, 32'h0009_0010, 32'h0002_0000, 32'h0040_0100, 0);
        run("R6 both in range", 0, 1, 1, 32'h0004_0007, 32'h0001_0001, 32'h0001_0001, 32'h0010_0010, 0);
    endtask

    task automatic t_wide_flag();
        run("R7 wide clamp", 0, 1, 0, 32'h0000_FFFF, 32'h0000_0001, 32'd0, 32'h0000_FFFF, 0);
        run("R7 wide no lane split", 0, 1, 0, 32'h0000_FFFF, 32'h0000_0001, 32'd0, 32'h0001_0000, 0);
    endtask

    task automatic t_sticky();
        // clear alone, no operation
        drive(0, 1, 0, 32'd0, 32'd0, 32'd0, 32'd0, 1, 0);
        exp_sticky = 2'b00;
        check("R9 clear alone", {30'd0, got_sticky}, 32'd0);
        run("R9 set lane1", 0, 1, 1, 32'hFFF0_0000, 32'h0100_0000, 32'h0000_0000, 32'h1000_FFFF, 0);
        run("R9 keep on clean op", 0, 1, 1, 32'h0001_0001, 32'h0001_0001, 32'h0000_0000, 32'h1000_1000, 0);
        run("R9 clear with clamp", 0, 1, 1, 32'h0000_00F0, 32'h0000_0020, 32'h0000_0000, 32'h1000_0100, 1);
        check("R9 clear then set", {30'd0, got_sticky}, 32'd1);
    endtask

    task automatic t_hold();
        logic [31:0] prev_res;
        logic [1:0]  prev_now;
        run("R10 prime", 0, 1, 0, 32'd40, 32'd2, 32'd0, 32'd100, 0);
        prev_res = got_res;
        prev_now = got_now;
        drive(1, 1, 0, 32'd1, 32'd9, 32'd5, 32'd6, 0, 0);
        check("R10 idle valid", {31'd0, got_vld}, 32'd0);
        check("R10 idle result", got_res, prev_res);
        check("R10 idle flags", {30'd0, got_now}, {30'd0, prev_now});
        check("R9 idle sticky", {30'd0, got_sticky}, {30'd0, exp_sticky});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add_wide();
        t_sub_wide();
        t_general();
        t_inverted();
        t_wrap();
        t_dual();
        t_wide_flag();
        t_sticky();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule